// File: doc/BRIEF.md
# VIPT Cache Alias Colour Detector

This block sits beside the mapping logic of a virtually-indexed, physically-tagged cache. It derives the colour of each new mapping. The colour is the set of virtual-address bits that index the cache above the page offset. For every physical page it tracks, it remembers the colour of the mapping that page received earlier. When a new mapping of that page uses another colour, the same data could sit in two cache sets. The block reports this as an alias and tells the requester to map the page uncached.

Two values set the colour width: the log2 of the page size and the log2 of one way's span (cache size divided by ways). If one way spans no more than a page, the colour width is zero and nothing can alias. Two physical pages at the same virtual index are harmless, because the tag compare uses the physical address. A flush notification tells the block that all cached data of a page has been written back and dropped. The page then returns to the wildcard state, and its next mapping may take any colour.

Tracking uses a direct-mapped table indexed by the low bits of the physical page number. Each slot holds a valid bit, the remaining page bits as a tag, the recorded colour and a shared-uncached flag. A request is answered one cycle after it is presented. No ready signal exists, because a request is accepted in every cycle.

Top module: `vipt_colour_guard`

## Requirements
- R1: The reported colour equals virtual address bits [SPAN_BITS-1:PAGE_BITS], which are the low (SPAN_BITS-PAGE_BITS) bits of the virtual page number. With the defaults (4 KB pages, 16 KB per way) this is reqVpn[1:0].
- R2: When SPAN_BITS <= PAGE_BITS, the colour width is zero. Every response is then cacheable (rspCacheable=1), with rspAlias=0 and rspColour=0.
- R3: A request for a physical page that is in the wildcard state is answered cacheable with rspAlias=0, and that request's colour is recorded for the page.
- R4: A request for a tracked page whose colour equals the recorded colour is answered cacheable with rspAlias=0.
- R5: A request for a tracked cacheable page with a different colour is answered uncached (rspCacheable=0) with rspAlias=1. The page then enters the shared-uncached state. The recorded colour does not change.
- R6: In the shared-uncached state, every request for the page is answered uncached. rspAlias=1 exactly when the request colour differs from the recorded colour.
- R7: A flush notification for a tracked page returns it to the wildcard state. The next request for it is cacheable, and that request's colour is recorded.
- R8: Without a flush notification, a page keeps its colour and state. Idle cycles, requests to other table slots, and flushes of other pages leave it unchanged.
- R9: Different physical pages are tracked independently, even when they are mapped at the same colour.
- R10: A response (rspValid=1) appears exactly one cycle after each request, and rspValid=0 in the cycle after a cycle with no request. Reset clears rspValid and returns every page to the wildcard state.
- R11: The table slot of a page is selected by reqPpn[IDX_W-1:0]. A request for a different page that maps to the same slot is treated as wildcard and replaces the slot, so the displaced page becomes wildcard.
- R12: When a flush and a request name the same page in the same cycle, the flush takes effect first. The request then sees the wildcard state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A mapping request is present this cycle |
| reqVpn | input | VPN_W | Virtual page number of the new mapping |
| reqPpn | input | PPN_W | Physical page number of the new mapping |
| flushValid | input | 1 | A page has been fully flushed from the cache |
| flushPpn | input | PPN_W | Physical page number that was flushed |
| rspValid | output | 1 | Response for the request of the previous cycle |
| rspCacheable | output | 1 | 1: map cached, 0: map uncached |
| rspAlias | output | 1 | The request colour differs from the page's recorded colour |
| rspColour | output | max(COLOUR_W,1) | Colour of the answered request |

## Verification
A corrupted slot shows up at the ports on the next request that hits the slot, one cycle after that request. A lost valid bit makes an aliasing request come back cacheable. A stale poison flag makes a matching-colour request come back uncached. A wrong recorded colour flips rspAlias. The bench therefore re-requests each page after every event that changes its state: a conflict, a flush, an eviction or a same-cycle flush. The order of the vectors makes every stored state visible in the response that follows.

// File: rtl/vcg_pkg.sv
package vcg_pkg;

  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic load;       // capture a response
    logic fresh;      // write a new slot (tag + colour)
    logic poison;     // move tracked page to shared-uncached
    logic clear;      // drop slot named by flush port
    logic cacheable;  // response value
    logic aliasHit;   // response value
  } vcgStrobe_t;

  function automatic int colourBits(input int pageBits, input int spanBits);
    return (spanBits > pageBits) ? (spanBits - pageBits) : 0;
  endfunction

endpackage

// File: rtl/vcg_ctrl.sv
module vcg_ctrl
  import vcg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       lkHit,
  input  logic       lkPoison,
  input  logic       lkMatch,
  input  logic       flHit,
  output vcgStrobe_t st
);

  always_comb begin
    st = '0;
    st.clear = flHit;
    if (reqValid) begin
      st.load = 1'b1;
      if (!lkHit) begin
        st.fresh     = 1'b1;
        st.cacheable = 1'b1;
      end else if (lkPoison) begin
        st.cacheable = 1'b0;
        st.aliasHit  = !lkMatch;
      end else if (!lkMatch) begin
        st.poison    = 1'b1;
        st.aliasHit  = 1'b1;
      end else begin
        st.cacheable = 1'b1;
      end
    end
  end

  // A conflict is only ever raised against a slot that the lookup found
  AST_POISON_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    st.poison |-> (lkHit && !lkPoison && !lkMatch)) else $error("poison without hit"); // R5

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(st.fresh || st.poison || st.load)) else $error("strobe while idle"); // R8

endmodule

// File: rtl/vcg_datapath.sv
module vcg_datapath
  import vcg_pkg::*;
#(
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int IDX_W    = 4,
  parameter int COLOUR_W = 2,
  parameter int CW_S     = (COLOUR_W > 0) ? COLOUR_W : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VPN_W-1:0] reqVpn,
  input  logic [PPN_W-1:0] reqPpn,
  input  logic             flushValid,
  input  logic [PPN_W-1:0] flushPpn,
  input  vcgStrobe_t       st,
  output logic             lkHit,
  output logic             lkPoison,
  output logic             lkMatch,
  output logic             flHit,
  output logic             rspValid,
  output logic             rspCacheable,
  output logic             rspAlias,
  output logic [CW_S-1:0]  rspColour
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PPN_W - IDX_W;

  logic [CW_S-1:0]  reqColour;
  logic             unusedVpnBits;

  generate
    if (COLOUR_W > 0) begin : g_colour
      assign reqColour = reqVpn[CW_S-1:0];
    end else begin : g_flat
      assign reqColour = '0;
    end
    if (COLOUR_W > 3) begin : g_too_wide
      $error("colour width above 3 bits is not supported");
    end
  endgenerate

  assign unusedVpnBits = ^reqVpn;

  logic [IDX_W-1:0] reqIdx, flIdx;
  logic [TAG_W-1:0] reqTag, flTag;
  assign reqIdx = reqPpn[IDX_W-1:0];
  assign reqTag = reqPpn[PPN_W-1:IDX_W];
  assign flIdx  = flushPpn[IDX_W-1:0];
  assign flTag  = flushPpn[PPN_W-1:IDX_W];

  logic             validQ  [ENTRIES];
  logic             poisonQ [ENTRIES];
  logic [TAG_W-1:0] tagQ    [ENTRIES];
  logic [CW_S-1:0]  colourQ [ENTRIES];

  // Lookup; a same-cycle flush of the same page wins over the stored slot
  logic flushSame;
  assign flushSame = flushValid && (flushPpn == reqPpn);
  assign lkHit     = validQ[reqIdx] && (tagQ[reqIdx] == reqTag) && !flushSame;
  assign lkPoison  = poisonQ[reqIdx];
  assign lkMatch   = (colourQ[reqIdx] == reqColour);
  assign flHit     = flushValid && validQ[flIdx] && (tagQ[flIdx] == flTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        validQ[i]  <= 1'b0;
        poisonQ[i] <= 1'b0;
      end
    end else begin
      if (st.clear) begin
        validQ[flIdx]  <= 1'b0;
        poisonQ[flIdx] <= 1'b0;
      end
      if (st.fresh) begin
        validQ[reqIdx]  <= 1'b1;
        poisonQ[reqIdx] <= 1'b0;
      end
      if (st.poison) begin
        poisonQ[reqIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.fresh) begin
      tagQ[reqIdx]    <= reqTag;
      colourQ[reqIdx] <= reqColour;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspCacheable <= 1'b0;
      rspAlias     <= 1'b0;
      rspColour    <= '0;
    end else begin
      rspValid <= st.load;
      if (st.load) begin
        rspCacheable <= st.cacheable;
        rspAlias     <= st.aliasHit;
        rspColour    <= reqColour;
      end
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid) else $error("missing response"); // R10

  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid) else $error("response without request"); // R10

  AST_ALIAS_UNCACHED: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAlias) |-> !rspCacheable) else $error("alias reported cacheable"); // R5

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (st.clear && !(st.fresh && (flIdx == reqIdx))) |=> !validQ[$past(flIdx)])
    else $error("flush left slot valid"); // R7

  AST_FRESH_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    st.fresh |=> (validQ[$past(reqIdx)] && !poisonQ[$past(reqIdx)]))
    else $error("fresh write lost"); // R3

  generate
    if (COLOUR_W == 0) begin : g_flat_chk
      AST_FLAT_CACHEABLE: assert property (@(posedge clk) disable iff (!rstN)
        rspValid |-> (rspCacheable && !rspAlias)) else $error("flat config uncached"); // R2
    end
  endgenerate

endmodule

// File: rtl/vipt_colour_guard.sv
module vipt_colour_guard
  import vcg_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int SPAN_BITS = 14,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int IDX_W     = 4,
  localparam int COLOUR_W = colourBits(PAGE_BITS, SPAN_BITS),
  localparam int CW_S     = (COLOUR_W > 0) ? COLOUR_W : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VPN_W-1:0] reqVpn,
  input  logic [PPN_W-1:0] reqPpn,
  input  logic             flushValid,
  input  logic [PPN_W-1:0] flushPpn,
  output logic             rspValid,
  output logic             rspCacheable,
  output logic             rspAlias,
  output logic [CW_S-1:0]  rspColour
);

  vcgStrobe_t st;
  logic lkHit, lkPoison, lkMatch, flHit;

  vcg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .lkHit    (lkHit),
    .lkPoison (lkPoison),
    .lkMatch  (lkMatch),
    .flHit    (flHit),
    .st       (st)
  );

  vcg_datapath #(
    .VPN_W    (VPN_W),
    .PPN_W    (PPN_W),
    .IDX_W    (IDX_W),
    .COLOUR_W (COLOUR_W),
    .CW_S     (CW_S)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqVpn       (reqVpn),
    .reqPpn       (reqPpn),
    .flushValid   (flushValid),
    .flushPpn     (flushPpn),
    .st           (st),
    .lkHit        (lkHit),
    .lkPoison     (lkPoison),
    .lkMatch      (lkMatch),
    .flHit        (flHit),
    .rspValid     (rspValid),
    .rspCacheable (rspCacheable),
    .rspAlias     (rspAlias),
    .rspColour    (rspColour)
  );

endmodule

// File: tb/tb_vipt_colour_guard.sv
module tb_vipt_colour_guard;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, flushValid;
  logic [19:0] reqVpn, reqPpn, flushPpn;
  logic rspValid, rspCacheable, rspAlias;
  logic [1:0] rspColour;
  logic fValid, fCacheable, fAlias;
  logic [0:0] fColour;

  always #10 clk = ~clk; // 50 MHz

  vipt_colour_guard dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVpn(reqVpn), .reqPpn(reqPpn),
    .flushValid(flushValid), .flushPpn(flushPpn), .rspValid(rspValid),
    .rspCacheable(rspCacheable), .rspAlias(rspAlias), .rspColour(rspColour)
  );

  // one way spans a single page: no colour bits
  vipt_colour_guard #(.SPAN_BITS(12)) dutFlat (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVpn(reqVpn), .reqPpn(reqPpn),
    .flushValid(flushValid), .flushPpn(flushPpn), .rspValid(fValid),
    .rspCacheable(fCacheable), .rspAlias(fAlias), .rspColour(fColour)
  );

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {reqV, vpn[20], ppn[20], flushV, flushPpn[20], expCacheable, expAlias}
  // Pages: A=0x00011 (slot1) B=0x00022 (slot2) C=0x00033 (slot3) D=0x00101 (slot1)
  localparam int NV = 20;
  localparam logic [63:0] VEC [NV] = '{
    {1'b1, 20'h00001, 20'h00011, 1'b0, 20'h0,     1'b1, 1'b0}, // R3 A wildcard, colour 1
    {1'b1, 20'h00105, 20'h00011, 1'b0, 20'h0,     1'b1, 1'b0}, // R4 A same colour
    {1'b1, 20'h00001, 20'h00022, 1'b0, 20'h0,     1'b1, 1'b0}, // R9 B same colour, other page
    {1'b0, 20'h0,     20'h0,     1'b0, 20'h0,     1'b0, 1'b0}, // R10 idle
    {1'b1, 20'h00003, 20'h00011, 1'b0, 20'h0,     1'b0, 1'b1}, // R5 A conflict
    {1'b1, 20'h00001, 20'h00011, 1'b0, 20'h0,     1'b0, 1'b0}, // R6 A shared, own colour
    {1'b1, 20'h00002, 20'h00011, 1'b0, 20'h0,     1'b0, 1'b1}, // R6 A shared, other colour
    {1'b0, 20'h0,     20'h0,     1'b1, 20'h00011, 1'b0, 1'b0}, // R7 flush A
    {1'b1, 20'h00002, 20'h00011, 1'b0, 20'h0,     1'b1, 1'b0}, // R7 A wildcard again, colour 2
    {1'b1, 20'h00003, 20'h00011, 1'b0, 20'h0,     1'b0, 1'b1}, // R7 colour 2 was recorded
    {1'b0, 20'h0,     20'h0,     1'b1, 20'h00101, 1'b0, 1'b0}, // R8 flush D (slot of A)
    {1'b1, 20'h00002, 20'h00011, 1'b0, 20'h0,     1'b0, 1'b0}, // R8 A still shared
    {1'b1, 20'h00009, 20'h00022, 1'b0, 20'h0,     1'b1, 1'b0}, // R8 B kept colour 1
    {1'b1, 20'h00000, 20'h00101, 1'b0, 20'h0,     1'b1, 1'b0}, // R11 D evicts A
    {1'b1, 20'h00003, 20'h00011, 1'b0, 20'h0,     1'b1, 1'b0}, // R11 A wildcard, evicts D
    {1'b1, 20'h00001, 20'h00011, 1'b1, 20'h00011, 1'b1, 1'b0}, // R12 flush + req A
    {1'b1, 20'h00002, 20'h00033, 1'b0, 20'h0,     1'b1, 1'b0}, // R3 C colour 2
    {1'b1, 20'h00003, 20'h00033, 1'b1, 20'h00033, 1'b1, 1'b0}, // R12 flush + req C
    {1'b1, 20'h00002, 20'h00011, 1'b1, 20'h00022, 1'b0, 1'b1}, // R5 A colour 1 vs 2
    {1'b1, 20'h00002, 20'h00022, 1'b0, 20'h0,     1'b1, 1'b0}  // R7 B flushed, wildcard
  };
  localparam int VTAG [NV] = '{3, 4, 9, 10, 5, 6, 6, 7, 7, 7, 8, 8, 8, 11, 11, 12, 3, 12, 5, 7};

  task automatic drive(input logic rv, input logic [19:0] vpn, input logic [19:0] ppn,
                       input logic fv, input logic [19:0] fppn);
    reqValid = rv; reqVpn = vpn; reqPpn = ppn; flushValid = fv; flushPpn = fppn;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    drive(1'b0, '0, '0, 1'b0, '0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    check("R10 reset rspValid", {31'b0, rspValid}, 32'd1 - 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vec%0d", VTAG[i], i);
      drive(v[63], v[62:43], v[42:23], v[22], v[21:2]);
      @(negedge clk);
      check({tg, " valid"}, {31'b0, rspValid}, {31'b0, v[63]});
      check({tg, " flat valid"}, {31'b0, fValid}, {31'b0, v[63]});
      if (v[63]) begin
        check({tg, " cacheable"}, {31'b0, rspCacheable}, {31'b0, v[1]});
        check({tg, " alias"}, {31'b0, rspAlias}, {31'b0, v[0]});
        check({tg, " R1 colour"}, {30'b0, rspColour}, {30'b0, v[44:43]});
        check({tg, " R2 flat cacheable"}, {31'b0, fCacheable}, 32'd1);
        check({tg, " R2 flat alias"}, {31'b0, fAlias}, 32'd0);
        check({tg, " R2 flat colour"}, {31'b0, fColour}, 32'd0);
      end
    end

    // R1: colour from high-valued virtual page number
    drive(1'b1, 20'hFFFFE, 20'h00044, 1'b0, '0);
    @(negedge clk);
    check("R1 colour vpn FFFFE", {30'b0, rspColour}, 32'd2);
    check("R3 new page cacheable", {31'b0, rspCacheable}, 32'd1);

    // R10: reset forgets every page; A was shared-uncached at colour 1
    doReset();
    check("R10 rspValid after reset", {31'b0, rspValid}, 32'd0);
    drive(1'b1, 20'h00002, 20'h00011, 1'b0, '0);
    @(negedge clk);
    check("R10 table cleared cacheable", {31'b0, rspCacheable}, 32'd1);
    check("R10 table cleared alias", {31'b0, rspAlias}, 32'd0);
    drive(1'b0, '0, '0, 1'b0, '0);
    @(negedge clk);
    check("R10 idle after request", {31'b0, rspValid}, 32'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule